// File: doc/BRIEF.md
# External Interrupt Sense and Status Unit

This block sits between seventeen asynchronous interrupt pins (one non-maskable pin and a bank of sixteen ordinary pins) and a downstream interrupt controller. Each pin is brought into the clock domain by a short flop chain and then goes to a detector. Software selects a sense mode for each pin. A detection sets a per-pin status flag, and that flag drives an active-high level request towards the controller.

Software reaches the block over a simple 32-bit register bus with single-cycle read and write strobes. There are three registers per pin group: status, write-one-to-clear, and sense select. A flag that was set by an edge stays set until software clears it. A flag in low-level mode tracks the pin and ignores software clears. The non-maskable pin supports only edge sensing, and its one-bit encoding differs from the two-bit encoding of the ordinary pins.

Top module: `ext_irq_sense_unit`

## Requirements
- R1: After a synchronous reset every sense field reads 0, every status flag is 0 and every request output is low.
- R2: Register offsets are: 0x00 non-maskable status (bit 0), 0x04 non-maskable clear, 0x08 non-maskable sense (bit 0), 0x10 ordinary status (bit n = pin n), 0x14 ordinary clear, 0x18 ordinary sense (pin n at bits [2n+1:2n]). Sense registers read back what was written. The clear offsets and any unmapped offset read 0. Read data is returned on the cycle after the read strobe.
- R3: Non-maskable sense bit 0 selects the falling edge and 1 selects the rising edge. Only the selected edge sets the flag. The flag appears three clock edges after the pin changes: two synchroniser stages, then the flag register.
- R4: Writing 1 to bit 0 at 0x04 clears the non-maskable flag. Writing 0 leaves the flag unchanged.
- R5: Ordinary sense codes are 0 low level, 1 falling edge, 2 rising edge and 3 both edges. An edge-sensed flag stays set until it is cleared.
- R6: Writing 1 to bit n at 0x14 clears status bit n only when pin n is edge-sensed. Bits written 0 are unaffected.
- R7: In low-level mode status bit n is 1 exactly while synchronised pin n is low. A clear write has no effect on it.
- R8: Each request output equals its status flag and is active high.
- R9: When a selected edge and a clear of the same flag fall in the same cycle, the flag ends set.
- R10: A write that changes a pin's sense field suppresses edge detection for that pin in that cycle and re-seeds its edge history, so the change produces no spurious edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_pins | input | 16 | Asynchronous ordinary interrupt pins |
| nmi_req | output | 1 | Non-maskable request, level high |
| irq_req | output | 16 | Ordinary requests, level high |

## Verification
The bench sweeps every ordinary pin through all four sense codes. For each one it checks the status and request after a falling edge, after a clear and after a rising edge. A design with a swapped code, a shifted field or a clear that reaches level-sensed flags would show a wrong bit in that grid. Targeted sequences line up a clear write with the detecting cycle: a design that gives the clear priority loses the edge. Other sequences line up a sense change with a pin edge: a design that keeps stale history would latch a spurious flag. Partial clears and zero-writes to the non-maskable clear catch a clear that acts on the whole register.

// File: rtl/xsu_pkg.sv
package xsu_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int unsigned OFS_NMI_STAT  = 'h00;
  localparam int unsigned OFS_NMI_CLR   = 'h04;
  localparam int unsigned OFS_NMI_SENSE = 'h08;
  localparam int unsigned OFS_IRQ_STAT  = 'h10;
  localparam int unsigned OFS_IRQ_CLR   = 'h14;
  localparam int unsigned OFS_IRQ_SENSE = 'h18;
endpackage

// File: rtl/xsu_sync.sv
module xsu_sync #(
  parameter int unsigned WIDTH  = 17,
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{IDLE}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xsu_detect.sv
module xsu_detect
  import xsu_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  sense_e mode,
  input  logic   mode_chg,
  input  logic   clr,
  output logic   flag
);
  logic prev;
  logic rise, fall, hit;

  assign rise = pin_s & ~prev;
  assign fall = ~pin_s & prev;

  always_comb begin
    unique case (mode)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
    if (mode_chg) hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= IDLE;
      flag <= 1'b0;
    end else begin
      prev <= pin_s;
      if (mode == SENSE_LOW) flag <= ~pin_s;
      else if (hit)          flag <= 1'b1;
      else if (clr)          flag <= 1'b0;
    end
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mode == SENSE_LOW) |=> (flag == !$past(pin_s))); // R7
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode == SENSE_RISE && !mode_chg && pin_s && !prev) |=> flag); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (mode != SENSE_LOW && clr && pin_s == prev) |=> !flag); // R6
  AST_CHANGE_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && mode != SENSE_LOW && !clr) |=> (flag == $past(flag))); // R10
endmodule

// File: rtl/ext_irq_sense_unit.sv
module ext_irq_sense_unit
  import xsu_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               nmi_pin,
  input  logic [NUM_IRQ-1:0] irq_pins,
  output logic               nmi_req,
  output logic [NUM_IRQ-1:0] irq_req
);
  localparam int unsigned NCH     = NUM_IRQ + 1;
  localparam int unsigned SENSE_W = 2 * NUM_IRQ;

  logic               nmi_sel;
  logic [SENSE_W-1:0] irq_sense;
  logic [NCH-1:0]     pins_s;
  logic [NUM_IRQ-1:0] irq_flag;
  logic               nmi_flag;

  logic wr_nclr, wr_nsense, wr_iclr, wr_isense;
  assign wr_nclr   = bus_wr && bus_addr == ADDR_W'(OFS_NMI_CLR);
  assign wr_nsense = bus_wr && bus_addr == ADDR_W'(OFS_NMI_SENSE);
  assign wr_iclr   = bus_wr && bus_addr == ADDR_W'(OFS_IRQ_CLR);
  assign wr_isense = bus_wr && bus_addr == ADDR_W'(OFS_IRQ_SENSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_sel   <= 1'b0;
      irq_sense <= '0;
    end else begin
      if (wr_nsense) nmi_sel   <= bus_wdata[0];
      if (wr_isense) irq_sense <= bus_wdata[SENSE_W-1:0];
    end
  end

  xsu_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d({irq_pins, nmi_pin}), .q(pins_s)
  );

  xsu_detect #(.IDLE(1'b1)) u_nmi_det (
    .clk      (clk),
    .rst      (rst),
    .pin_s    (pins_s[0]),
    .mode     (nmi_sel ? SENSE_RISE : SENSE_FALL),
    .mode_chg (wr_nsense && (bus_wdata[0] != nmi_sel)),
    .clr      (wr_nclr && bus_wdata[0]),
    .flag     (nmi_flag)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    xsu_detect #(.IDLE(1'b1)) u_det (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (pins_s[i+1]),
      .mode     (sense_e'(irq_sense[2*i +: 2])),
      .mode_chg (wr_isense && (bus_wdata[2*i +: 2] != irq_sense[2*i +: 2])),
      .clr      (wr_iclr && bus_wdata[i]),
      .flag     (irq_flag[i])
    );
  end

  assign nmi_req = nmi_flag;
  assign irq_req = irq_flag;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_NMI_STAT))       rd_mux[0] = nmi_flag;
    else if (bus_addr == ADDR_W'(OFS_NMI_SENSE)) rd_mux[0] = nmi_sel;
    else if (bus_addr == ADDR_W'(OFS_IRQ_STAT))  rd_mux[NUM_IRQ-1:0] = irq_flag;
    else if (bus_addr == ADDR_W'(OFS_IRQ_SENSE)) rd_mux[SENSE_W-1:0] = irq_sense;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && !nmi_req)); // R1
  AST_NMI_ZERO_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_nclr && !bus_wdata[0] && nmi_flag) |=> nmi_flag); // R4
endmodule

// File: tb/tb_ext_irq_sense_unit.sv
`timescale 1ns/1ps
module tb_ext_irq_sense_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nmi_pin = 1'b1;
  logic [15:0] irq_pins = 16'hFFFF;
  logic        nmi_req;
  logic [15:0] irq_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense_unit dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_pin(nmi_pin),
    .irq_pins(irq_pins), .nmi_req(nmi_req), .irq_req(irq_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    tick(4);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    chk("R1 irq_req", {16'h0, irq_req}, 0);
    chk("R1 nmi_req", {31'h0, nmi_req}, 0);
    rd(8'h00, v); chk("R1 nmi status", v, 0);
    rd(8'h10, v); chk("R1 irq status", v, 0);
    rd(8'h08, v); chk("R1 nmi sense", v, 0);
    rd(8'h18, v); chk("R1 irq sense", v, 0);

    // R2 map and readback
    rd(8'h14, v); chk("R2 clear reads 0", v, 0);
    rd(8'h04, v); chk("R2 nmi clear reads 0", v, 0);
    rd(8'h40, v); chk("R2 unmapped reads 0", v, 0);
    wr(8'h18, 32'h1B1BE4E4); rd(8'h18, v); chk("R2 irq sense readback", v, 32'h1B1BE4E4);
    wr(8'h18, 0);
    wr(8'h08, 1); rd(8'h08, v); chk("R2 nmi sense readback", v, 1);
    wr(8'h08, 0); tick(2);

    // R3/R4 non-maskable pin, falling mode
    nmi_pin = 1'b0; tick(2);
    chk("R3 latency not early", {31'h0, nmi_req}, 0);
    tick(1);
    chk("R3 falling sets req", {31'h0, nmi_req}, 1);
    rd(8'h00, v); chk("R3 falling sets status", v, 1);
    wr(8'h04, 0); rd(8'h00, v); chk("R4 zero write keeps", v, 1);
    wr(8'h04, 1); rd(8'h00, v); chk("R4 clear", v, 0);
    nmi_pin = 1'b1; tick(3);
    rd(8'h00, v); chk("R3 rising ignored in falling mode", v, 0);
    wr(8'h08, 1); tick(2);
    nmi_pin = 1'b0; tick(3);
    rd(8'h00, v); chk("R3 falling ignored in rising mode", v, 0);
    nmi_pin = 1'b1; tick(3);
    rd(8'h00, v); chk("R3 rising sets", v, 1);
    chk("R8 nmi req follows", {31'h0, nmi_req}, 1);
    wr(8'h04, 1); wr(8'h08, 0); tick(2);

    // R5..R8 sweep over every pin and mode
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bit_n;
        bit_n = 32'h1 << n;
        wr(8'h18, 32'(m) << (2 * n)); tick(2);
        wr(8'h14, 32'hFFFF); tick(1);
        rd(8'h10, v); chk("R5 baseline", v, 0);
        irq_pins[n] = 1'b0; tick(3);
        e = (m != 2) ? bit_n : 0;
        rd(8'h10, v); chk("R5 after fall", v, e);
        chk("R8 req after fall", {16'h0, irq_req}, e);
        wr(8'h14, bit_n); tick(1);
        e = (m == 0) ? bit_n : 0;
        rd(8'h10, v); chk(m == 0 ? "R7 clear ignored" : "R6 clear", v, e);
        irq_pins[n] = 1'b1; tick(3);
        e = (m >= 2) ? bit_n : 0;
        rd(8'h10, v); chk(m == 0 ? "R7 follows release" : "R5 after rise", v, e);
        chk("R8 req after rise", {16'h0, irq_req}, e);
        wr(8'h14, 32'hFFFF);
      end
    end
    wr(8'h18, 0); tick(2);

    // R6 partial clear: pins 2 and 3 falling edge, clear only bit 2
    wr(8'h18, 32'h50); tick(2);
    irq_pins[3:2] = 2'b00; tick(3);
    rd(8'h10, v); chk("R6 both set", v, 32'hC);
    wr(8'h14, 32'h4); rd(8'h10, v); chk("R6 partial clear", v, 32'h8);
    irq_pins[3:2] = 2'b11; wr(8'h14, 32'hFFFF); tick(3);

    // R9 edge and clear in the same cycle, pin 5 rising
    wr(8'h18, 32'h2 << 10); irq_pins[5] = 1'b0; tick(3);
    wr(8'h14, 32'hFFFF); tick(1);
    irq_pins[5] = 1'b1; tick(2);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R9 edge beats clear", v, 32'h20);
    wr(8'h14, 32'hFFFF);

    // R10 sense change at the detecting cycle, pin 7 falling -> rising
    wr(8'h18, 32'h1 << 14); tick(3);
    wr(8'h14, 32'hFFFF);
    irq_pins[7] = 1'b0; tick(2);
    wr(8'h18, 32'h2 << 14);
    rd(8'h10, v); chk("R10 no spurious edge", v, 0);
    irq_pins[7] = 1'b1; tick(3);
    rd(8'h10, v); chk("R10 new mode active", v, 32'h80);

    // R10 on the non-maskable pin: falling -> rising while pin falls
    wr(8'h04, 1);
    nmi_pin = 1'b0; tick(2);
    wr(8'h08, 1);
    rd(8'h00, v); chk("R10 nmi no spurious edge", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule